// File: doc/BRIEF.md
# Window Limit Watchdog Comparator

This block watches a stream of signed samples that carry eight bits of magnitude plus a sign. It raises an interrupt request when a sample falls outside a window that the user has programmed. The block first applies an offset correction coefficient to each accepted sample, and the corrected value is clamped to the sample range. It then compares the result against two limits that come with the current instruction. Each limit has its own direction flag. The flag selects whether the limit trips when the sample is above it or when the sample is below it. With one limit tripping above and the other tripping below, the pair flags a signal that leaves a band. With both limits pointing the same way, the pair flags two separate threshold crossings.

Each limit owns a sticky status bit. Once a limit trips, its bit stays set until the host acknowledges that bit. The interrupt request is the OR of the two status bits, and each bit passes through its own enable first. The upstream sampler presents a sample with a one-cycle valid strobe. The host reads the status bits and clears them with the acknowledge inputs.

Top module: `window_watchdog`

## Requirements
- R1: After reset, both status bits and the interrupt request are 0.
- R2: The corrected sample is the sample minus the offset coefficient, both signed two's complement, clamped to the range -256..255. A difference above 255 becomes 255 and a difference below -256 becomes -256.
- R3: A limit whose direction flag is 1 trips when the corrected sample is strictly greater than that limit. An equal value does not trip it.
- R4: A limit whose direction flag is 0 trips when the corrected sample is strictly less than that limit. An equal value does not trip it.
- R5: The sampleValid strobe is sampled high at one rising edge, which captures the sample, offset, limits and flags. A trip from that sample sets its status bit at the next rising edge.
- R6: A set status bit stays set through later non-tripping samples until its own acknowledge is seen.
- R7: An acknowledge clears only its own status bit. If a new trip for the same limit arrives at the same edge as its acknowledge, the bit stays set.
- R8: The interrupt request equals (statusA AND enA) OR (statusB AND enB). The enables have no effect on the status bits.
- R9: Sample, offset, limit and flag inputs present while sampleValid is low have no effect on the status bits.
- R10: Upper limit with flag 1 and lower limit with flag 0 form a band. Samples inside the band or on its edges set no status bit, and samples outside set the bit of the limit they cross.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | One-cycle strobe marking a new sample |
| sampleData | input | 9 | Signed sample |
| offsetCoef | input | 6 | Signed offset coefficient subtracted from the sample |
| limitA | input | 9 | Signed first limit |
| limitB | input | 9 | Signed second limit |
| dirA | input | 1 | First limit direction: 1 trips above, 0 trips below |
| dirB | input | 1 | Second limit direction: 1 trips above, 0 trips below |
| enA | input | 1 | Interrupt enable for the first status bit |
| enB | input | 1 | Interrupt enable for the second status bit |
| ackA | input | 1 | Clears the first status bit |
| ackB | input | 1 | Clears the second status bit |
| statusA | output | 1 | Sticky trip status of the first limit |
| statusB | output | 1 | Sticky trip status of the second limit |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to create from the ports is the same-edge collision. A fresh trip has to reach the status register at the very edge where the host acknowledges that bit. The stimulus gets there by timing: it raises sampleValid, then raises the acknowledge in the following cycle, which is exactly when the captured sample is evaluated. Clamp behaviour needs the second hard case. The bench drives samples at both ends of the range with an offset of the sign that pushes them past the end. It places a limit so that a wrapped result would give the opposite trip decision.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int NUM_LIM = 2;

  typedef struct packed {
    logic capture;   // latch sample and instruction fields
    logic evaluate;  // compare latched values this cycle
  } wdg_strobe_t;
endpackage

// File: rtl/wdg_datapath.sv
module wdg_datapath
  import wdg_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int OFS_W  = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  wdg_strobe_t                    strobe,
  input  logic [DATA_W-1:0]              sampleIn,
  input  logic [OFS_W-1:0]               offsetIn,
  input  logic [NUM_LIM-1:0][DATA_W-1:0] limitIn,
  input  logic [NUM_LIM-1:0]             dirIn,
  output logic [NUM_LIM-1:0]             hitOut
);
  localparam int EXT_W = DATA_W + 1;
  localparam logic [DATA_W-1:0] MAX_VAL = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_VAL = {1'b1, {(DATA_W-1){1'b0}}};

  logic [EXT_W-1:0] sampleExt;
  logic [EXT_W-1:0] offsetExt;
  logic [EXT_W-1:0] diffWide;
  logic [DATA_W-1:0] corrNext;
  logic [DATA_W-1:0] corrReg;
  logic [NUM_LIM-1:0][DATA_W-1:0] limReg;
  logic [NUM_LIM-1:0] dirReg;

  assign sampleExt = {sampleIn[DATA_W-1], sampleIn};
  assign offsetExt = {{(EXT_W-OFS_W){offsetIn[OFS_W-1]}}, offsetIn};
  assign diffWide  = sampleExt - offsetExt;

  // clamp when the two top bits of the wide difference disagree
  always_comb begin
    if (diffWide[EXT_W-1] != diffWide[EXT_W-2])
      corrNext = diffWide[EXT_W-1] ? MIN_VAL : MAX_VAL;
    else
      corrNext = diffWide[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corrReg <= '0;
      limReg  <= '0;
      dirReg  <= '0;
    end else if (strobe.capture) begin
      corrReg <= corrNext;
      limReg  <= limitIn;
      dirReg  <= dirIn;
    end
  end

  for (genvar i = 0; i < NUM_LIM; i++) begin : g_cmp
    logic above, below;
    assign above = $signed(corrReg) > $signed(limReg[i]);
    assign below = $signed(corrReg) < $signed(limReg[i]);
    assign hitOut[i] = strobe.evaluate & (dirReg[i] ? above : below);
  end

  // R9: captured values only move on a capture strobe
  p_capture_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.capture |=> $stable(corrReg) && $stable(limReg) && $stable(dirReg));

  // R5: a hit is only reported in an evaluate cycle
  p_hit_needs_eval_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hitOut != '0) |-> strobe.evaluate);
endmodule

// File: rtl/wdg_control.sv
module wdg_control
  import wdg_pkg::*;
#(
  parameter int NLIM = NUM_LIM
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sampleValid,
  input  logic [NLIM-1:0] ackIn,
  input  logic [NLIM-1:0] enIn,
  input  logic [NLIM-1:0] hitIn,
  output wdg_strobe_t     strobe,
  output logic [NLIM-1:0] statusOut,
  output logic            irqOut
);
  logic evalPend;
  logic [NLIM-1:0] statusReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evalPend <= 1'b0;
    else        evalPend <= sampleValid;
  end

  assign strobe.capture  = sampleValid;
  assign strobe.evaluate = evalPend;

  // a new trip wins over an acknowledge at the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) statusReg <= '0;
    else        statusReg <= (statusReg & ~ackIn) | hitIn;
  end

  assign statusOut = statusReg;
  assign irqOut    = |(statusReg & enIn);

  for (genvar i = 0; i < NLIM; i++) begin : g_chk
    // R6: sticky without acknowledge
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      statusReg[i] && !ackIn[i] |=> statusReg[i]);
    // R7: acknowledge clears when no fresh trip
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ackIn[i] && !hitIn[i] |=> !statusReg[i]);
    // R5: a status rise is caused by a hit one edge earlier
    p_rise_from_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(statusReg[i]) |-> $past(hitIn[i]));
  end

  // R8: request only with some status set
  p_irq_needs_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> (statusReg != '0));
endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
  import wdg_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int OFS_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  input  logic [OFS_W-1:0]  offsetCoef,
  input  logic [DATA_W-1:0] limitA,
  input  logic [DATA_W-1:0] limitB,
  input  logic              dirA,
  input  logic              dirB,
  input  logic              enA,
  input  logic              enB,
  input  logic              ackA,
  input  logic              ackB,
  output logic              statusA,
  output logic              statusB,
  output logic              irq
);
  wdg_strobe_t strobe;
  logic [NUM_LIM-1:0] hit;
  logic [NUM_LIM-1:0] status;
  logic [NUM_LIM-1:0][DATA_W-1:0] limitVec;

  assign limitVec = {limitB, limitA};

  wdg_datapath #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .sampleIn(sampleData), .offsetIn(offsetCoef),
    .limitIn(limitVec), .dirIn({dirB, dirA}), .hitOut(hit)
  );

  wdg_control #(.NLIM(NUM_LIM)) u_ctl (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid),
    .ackIn({ackB, ackA}), .enIn({enB, enA}), .hitIn(hit),
    .strobe(strobe), .statusOut(status), .irqOut(irq)
  );

  assign statusA = status[0];
  assign statusB = status[1];
endmodule

// File: tb/sim_window_watchdog.sv
module sim_window_watchdog;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sampleValid = 1'b0;
  logic [8:0] sampleData = '0;
  logic [5:0] offsetCoef = '0;
  logic [8:0] limitA = '0, limitB = '0;
  logic dirA = 1'b0, dirB = 1'b0, enA = 1'b0, enB = 1'b0, ackA = 1'b0, ackB = 1'b0;
  logic statusA, statusB, irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  window_watchdog u0 (.*);

  function automatic bit expTrip(int s, int o, int lim, bit dir);
    int d = s - o;
    if (d > 255) d = 255;
    if (d < -256) d = -256;
    return dir ? (d > lim) : (d < lim);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ack(bit a, bit b);
    @(negedge clk); ackA = a; ackB = b;
    @(negedge clk); ackA = 0; ackB = 0;
  endtask

  task automatic apply(int s, int o, int la, int lb, bit da, bit db);
    @(negedge clk);
    sampleData = 9'(s); offsetCoef = 6'(o);
    limitA = 9'(la); limitB = 9'(lb); dirA = da; dirB = db;
    sampleValid = 1;
    @(negedge clk); sampleValid = 0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 statusA", statusA, 0);
    check("R1 statusB", statusB, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_above_below;
    apply(100, 0, 99, 101, 1, 0);
    check("R3 above trips", statusA, 1);
    check("R4 below trips", statusB, 1);
    ack(1, 1);
    apply(-50, 0, -50, -50, 1, 0);
    check("R3 equal no trip", statusA, 0);
    check("R4 equal no trip", statusB, 0);
    apply(-120, 0, -121, -119, 0, 1);
    check("R3 signed not above", statusB, 0);
    check("R4 signed not below", statusA, 0);
  endtask

  task automatic t_offset;
    apply(10, 5, 5, 5, 1, 0);
    check("R2 offset equal", statusA, expTrip(10, 5, 5, 1));
    apply(10, -3, 12, 12, 1, 0);
    check("R2 negative offset", statusA, expTrip(10, -3, 12, 1));
    ack(1, 1);
    apply(255, -31, 254, 0, 1, 1);
    check("R2 clamp high", statusA, expTrip(255, -31, 254, 1));
    ack(1, 1);
    apply(-256, 31, -255, 0, 0, 0);
    check("R2 clamp low", statusA, expTrip(-256, 31, -255, 0));
    ack(1, 1);
  endtask

  task automatic t_timing;
    @(negedge clk);
    sampleData = 9'(50); limitA = 9'(0); dirA = 1; offsetCoef = 0;
    limitB = 9'(-256); dirB = 0; sampleValid = 1;
    @(negedge clk); sampleValid = 0;
    check("R5 not yet set", statusA, 0);
    @(negedge clk);
    check("R5 set one edge later", statusA, 1);
    ack(1, 0);
  endtask

  task automatic t_sticky_ack;
    apply(80, 0, 70, 90, 1, 0);
    apply(0, 0, 100, -100, 1, 0);
    check("R6 A sticky", statusA, 1);
    check("R6 B sticky", statusB, 1);
    ack(1, 0);
    check("R7 A cleared", statusA, 0);
    check("R7 B untouched", statusB, 1);
    // collision: fresh trip on B at the edge that acks B
    @(negedge clk);
    sampleData = 9'(-10); limitA = 9'(100); dirA = 1;
    limitB = 9'(0); dirB = 0; sampleValid = 1;
    @(negedge clk); sampleValid = 0; ackB = 1;
    @(negedge clk); ackB = 0;
    check("R7 trip wins over ack", statusB, 1);
    ack(0, 1);
    check("R7 ack after collision", statusB, 0);
  endtask

  task automatic t_enable;
    apply(20, 0, 10, -100, 1, 0);
    @(negedge clk); enA = 0; enB = 1;
    @(negedge clk);
    check("R8 irq gated", irq, 0);
    check("R8 status kept", statusA, 1);
    enA = 1;
    @(negedge clk);
    check("R8 irq raised", irq, 1);
    ack(1, 0);
    check("R8 irq dropped", irq, 0);
  endtask

  task automatic t_ignore;
    @(negedge clk);
    sampleData = 9'(200); limitA = 9'(0); dirA = 1;
    limitB = 9'(255); dirB = 0; sampleValid = 0;
    repeat (4) @(negedge clk);
    check("R9 A ignored", statusA, 0);
    check("R9 B ignored", statusB, 0);
  endtask

  task automatic t_window;
    int pts[5] = '{-40, -41, 0, 60, 61};
    foreach (pts[k]) begin
      apply(pts[k], 0, 60, -40, 1, 0);
      check("R10 upper edge", statusA, expTrip(pts[k], 0, 60, 1));
      check("R10 lower edge", statusB, expTrip(pts[k], 0, -40, 0));
      ack(1, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_reset();
    t_above_below();
    ack(1, 1);
    t_offset();
    t_timing();
    t_sticky_ack();
    t_enable();
    t_ignore();
    t_window();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule